// File: doc/BRIEF.md
# Display Enable Power Sequencer

This block starts and stops a display controller and takes an attached LCD panel through its power-up and power-down steps. Software drives it through a small register window. A 16-bit control register holds a display-on bit and a self-clearing start bit. A second, event register reports the 2-bit progress code, a sticky completion flag and a sticky misuse flag.

Power-up runs the controller first and then raises the panel logic supply, the panel drive voltage and the display enable, in that order. Power-down lowers them in reverse and stops the controller last. Each step lasts a parameterised number of clock cycles. Software starts a sequence, waits for the completion flag or the interrupt output, and checks the progress code. It must leave the control register alone while a sequence is running.

Top module: `disp_pwr_seq`

## Requirements
- R1: The control register (address 0) is 16 bits wide and resets to 0x0000. Only bit 0 (display on) and bit 4 (start) hold state. All other bits read as 0 and ignore writes.
- R2: After a start is accepted, bit 4 of the control register reads 1 for exactly one cycle and then reads 0 with no further write.
- R3: Power-up begins only when one control write has bit 4 = 1 and bit 0 = 1 while display-on is 0 and the block is off. A write of bit 0 = 1 with bit 4 = 0 leaves every output off and display-on at 0.
- R4: Take the edge that accepts a start as edge k. After edge k, ctrl_run is 1. After edge k+DLY_LOGIC, pnl_logic_en is 1. After edge k+DLY_LOGIC+DLY_DRIVE, pnl_drive_en is 1. After edge k+DLY_LOGIC+DLY_DRIVE+DLY_DISP, pnl_disp_en is 1.
- R5: During power-up, seq_status reads 00 until the logic supply is up, then 01, then 11 once the display enable is up. The code 10 never appears.
- R6: Power-down begins when a control write has bit 0 = 0 while display-on is 1 and seq_status is 11.
- R7: Take the edge that accepts a stop as edge k. After edge k, pnl_disp_en is 0 and the status is still 11. After edge k+DLY_DISP, pnl_drive_en is 0 and the status is 01. After a further DLY_DRIVE edges, pnl_logic_en is 0. After a further DLY_LOGIC edges, ctrl_run is 0 and the status is 00.
- R8: A control write that arrives while a sequence is running changes neither the register nor the sequence. It sets the error flag, bit 5 of the event register (address 1). Writing 1 to that bit clears the flag.
- R9: When either sequence completes, the done flag (bit 4 of the event register) and done_irq become 1 and stay 1 until 1 is written to bit 4. Bits 1:0 of the event register mirror seq_status.
- R10: The enables are nested at all times. pnl_disp_en implies pnl_drive_en, pnl_drive_en implies pnl_logic_en, and pnl_logic_en implies ctrl_run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address (0 control, 1 event) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| ctrl_run | output | 1 | Display controller run enable |
| pnl_logic_en | output | 1 | Panel logic supply enable |
| pnl_drive_en | output | 1 | Panel drive voltage enable |
| pnl_disp_en | output | 1 | Panel display enable |
| seq_status | output | 2 | Progress code 00 / 01 / 11 |
| done_irq | output | 1 | Sticky completion interrupt |

## Verification
The bench applies four kinds of control write and follows each cycle by cycle.

- A full start (both bits set) shows the power-up order and step timing.
- A write of display-on alone shows that the start bit is really required.
- A clearing write from the on state shows the power-down order.
- Writes made in the middle of each sequence separate a correctly ignored write from one that corrupts the phase or the register.

A second start after a full power-down confirms that the block returns to a clean off state.

// File: rtl/disp_seq_pkg.sv
package disp_seq_pkg;

  localparam int REG_W          = 16;
  localparam int CTRL_ON_BIT    = 0;
  localparam int CTRL_START_BIT = 4;
  localparam int EVT_DONE_BIT   = 4;
  localparam int EVT_ERR_BIT    = 5;

  typedef enum logic [2:0] {
    PH_OFF,
    PH_UP_RUN,
    PH_UP_LOGIC,
    PH_UP_DRIVE,
    PH_ON,
    PH_DN_DRIVE,
    PH_DN_LOGIC,
    PH_DN_RUN
  } phase_e;

  typedef struct packed {
    logic [1:0] status;
    logic       run;
    logic       logic_en;
    logic       drive_en;
    logic       disp_en;
  } pwr_vec_t;

  // Output pattern held while in each phase
  function automatic pwr_vec_t phase_outputs(input phase_e p);
    pwr_vec_t v;
    case (p)
      PH_UP_RUN:   v = '{status: 2'b00, run: 1'b1, logic_en: 1'b0, drive_en: 1'b0, disp_en: 1'b0};
      PH_UP_LOGIC: v = '{status: 2'b01, run: 1'b1, logic_en: 1'b1, drive_en: 1'b0, disp_en: 1'b0};
      PH_UP_DRIVE: v = '{status: 2'b01, run: 1'b1, logic_en: 1'b1, drive_en: 1'b1, disp_en: 1'b0};
      PH_ON:       v = '{status: 2'b11, run: 1'b1, logic_en: 1'b1, drive_en: 1'b1, disp_en: 1'b1};
      PH_DN_DRIVE: v = '{status: 2'b11, run: 1'b1, logic_en: 1'b1, drive_en: 1'b1, disp_en: 1'b0};
      PH_DN_LOGIC: v = '{status: 2'b01, run: 1'b1, logic_en: 1'b1, drive_en: 1'b0, disp_en: 1'b0};
      PH_DN_RUN:   v = '{status: 2'b01, run: 1'b1, logic_en: 1'b0, drive_en: 1'b0, disp_en: 1'b0};
      default:     v = '0;
    endcase
    return v;
  endfunction

  function automatic logic phase_busy(input phase_e p);
    return (p != PH_OFF) && (p != PH_ON);
  endfunction

  function automatic phase_e phase_next(input phase_e p);
    case (p)
      PH_UP_RUN:   return PH_UP_LOGIC;
      PH_UP_LOGIC: return PH_UP_DRIVE;
      PH_UP_DRIVE: return PH_ON;
      PH_DN_DRIVE: return PH_DN_LOGIC;
      PH_DN_LOGIC: return PH_DN_RUN;
      PH_DN_RUN:   return PH_OFF;
      default:     return p;
    endcase
  endfunction

  // Width of a counter able to hold values up to max_val
  function automatic int cnt_width(input int max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction

endpackage

// File: rtl/disp_step_timer.sv
module disp_step_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             active,
  input  logic [CNT_W-1:0] len,
  output logic             expire
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else if (active)  cnt_q <= cnt_q + 1'b1;
  end

  assign expire = active && (cnt_q == CNT_W'(len - 1'b1));

endmodule

// File: rtl/disp_phase_fsm.sv
module disp_phase_fsm
  import disp_seq_pkg::*;
#(
  parameter int DLY_LOGIC = 16,
  parameter int DLY_DRIVE = 32,
  parameter int DLY_DISP  = 8
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start_trig,
  input  logic   stop_trig,
  output phase_e phase,
  output logic   step_go,
  output logic   done_pulse
);

  localparam int MAX_DLY = (DLY_LOGIC > DLY_DRIVE) ?
                           ((DLY_LOGIC > DLY_DISP) ? DLY_LOGIC : DLY_DISP) :
                           ((DLY_DRIVE > DLY_DISP) ? DLY_DRIVE : DLY_DISP);
  localparam int CNT_W   = cnt_width(MAX_DLY);

  phase_e           phase_q;
  phase_e           phase_d;
  logic             expire;
  logic [CNT_W-1:0] step_len;

  // Dwell time of each timed phase
  function automatic logic [CNT_W-1:0] phase_len(input phase_e p);
    case (p)
      PH_UP_RUN, PH_DN_RUN:     return CNT_W'(DLY_LOGIC);
      PH_UP_LOGIC, PH_DN_LOGIC: return CNT_W'(DLY_DRIVE);
      PH_UP_DRIVE, PH_DN_DRIVE: return CNT_W'(DLY_DISP);
      default:                  return '1;
    endcase
  endfunction

  assign step_len = phase_len(phase_q);

  disp_step_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (step_go),
    .active  (phase_busy(phase_q)),
    .len     (step_len),
    .expire  (expire)
  );

  always_comb begin
    phase_d = phase_q;
    if (phase_q == PH_OFF && start_trig)  phase_d = PH_UP_RUN;
    else if (phase_q == PH_ON && stop_trig) phase_d = PH_DN_DRIVE;
    else if (expire)                      phase_d = phase_next(phase_q);
  end

  assign step_go    = (phase_d != phase_q);
  assign done_pulse = expire && (phase_q == PH_UP_DRIVE || phase_q == PH_DN_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_OFF;
    else        phase_q <= phase_d;
  end

  assign phase = phase_q;

endmodule

// File: rtl/disp_ctrl_regs.sv
module disp_ctrl_regs
  import disp_seq_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  phase_e            phase,
  input  logic [1:0]        status,
  input  logic              done_pulse,
  output logic              on_q,
  output logic              start_q,
  output logic              err_q,
  output logic              done_q,
  output logic              start_trig,
  output logic              stop_trig,
  output logic              busy_wr
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_EVT  = ADDR_W'(1);

  logic ctrl_wr;
  logic evt_wr;
  logic wr_on;
  logic wr_start;
  logic busy;

  assign ctrl_wr  = bus_wr && (bus_addr == A_CTRL);
  assign evt_wr   = bus_wr && (bus_addr == A_EVT);
  assign wr_on    = bus_wdata[CTRL_ON_BIT];
  assign wr_start = bus_wdata[CTRL_START_BIT];
  assign busy     = phase_busy(phase);

  assign busy_wr    = ctrl_wr && busy;
  assign start_trig = ctrl_wr && !busy && (phase == PH_OFF) && !on_q && wr_on && wr_start;
  assign stop_trig  = ctrl_wr && !busy && (phase == PH_ON) && on_q && !wr_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q    <= 1'b0;
      start_q <= 1'b0;
    end else begin
      start_q <= start_trig;
      if (start_trig)     on_q <= 1'b1;
      else if (stop_trig) on_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (busy_wr)                                    err_q <= 1'b1;
      else if (evt_wr && bus_wdata[EVT_ERR_BIT])      err_q <= 1'b0;
      if (done_pulse)                                 done_q <= 1'b1;
      else if (evt_wr && bus_wdata[EVT_DONE_BIT])     done_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_CTRL) begin
      bus_rdata[CTRL_ON_BIT]    = on_q;
      bus_rdata[CTRL_START_BIT] = start_q;
    end else if (bus_addr == A_EVT) begin
      bus_rdata[1:0]          = status;
      bus_rdata[EVT_DONE_BIT] = done_q;
      bus_rdata[EVT_ERR_BIT]  = err_q;
    end
  end

endmodule

// File: rtl/disp_pwr_seq.sv
module disp_pwr_seq
  import disp_seq_pkg::*;
#(
  parameter int ADDR_W    = 2,
  parameter int DLY_LOGIC = 16,
  parameter int DLY_DRIVE = 32,
  parameter int DLY_DISP  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              ctrl_run,
  output logic              pnl_logic_en,
  output logic              pnl_drive_en,
  output logic              pnl_disp_en,
  output logic [1:0]        seq_status,
  output logic              done_irq
);

  phase_e   phase;
  pwr_vec_t pv;
  logic     start_trig;
  logic     stop_trig;
  logic     step_go;
  logic     done_pulse;
  logic     on_q;
  logic     start_q;
  logic     err_q;
  logic     done_q;
  logic     busy_wr;

  disp_ctrl_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .phase      (phase),
    .status     (pv.status),
    .done_pulse (done_pulse),
    .on_q       (on_q),
    .start_q    (start_q),
    .err_q      (err_q),
    .done_q     (done_q),
    .start_trig (start_trig),
    .stop_trig  (stop_trig),
    .busy_wr    (busy_wr)
  );

  disp_phase_fsm #(
    .DLY_LOGIC (DLY_LOGIC),
    .DLY_DRIVE (DLY_DRIVE),
    .DLY_DISP  (DLY_DISP)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_trig (start_trig),
    .stop_trig  (stop_trig),
    .phase      (phase),
    .step_go    (step_go),
    .done_pulse (done_pulse)
  );

  assign pv           = phase_outputs(phase);
  assign ctrl_run     = pv.run;
  assign pnl_logic_en = pv.logic_en;
  assign pnl_drive_en = pv.drive_en;
  assign pnl_disp_en  = pv.disp_en;
  assign seq_status   = pv.status;
  assign done_irq     = done_q;

endmodule

// File: rtl/disp_seq_chk.sv
module disp_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ctrl_run,
  input logic       pnl_logic_en,
  input logic       pnl_drive_en,
  input logic       pnl_disp_en,
  input logic [1:0] seq_status,
  input logic       done_irq,
  input logic       on_q,
  input logic       start_q,
  input logic       err_q,
  input logic       busy_wr,
  input logic       start_trig,
  input logic       stop_trig,
  input logic       done_pulse
);

  // R10
  nested_enables_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pnl_disp_en || pnl_drive_en) && (!pnl_drive_en || pnl_logic_en) && (!pnl_logic_en || ctrl_run));

  // R5
  no_status_10_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_status != 2'b10);

  // R2
  start_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q);

  // R8
  busy_write_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_wr |=> err_q);

  // R8
  busy_write_keeps_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_wr |=> (on_q == $past(on_q)));

  // R9
  done_sets_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> done_irq);

  // R4
  start_runs_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_trig |=> (ctrl_run && !pnl_logic_en && on_q));

  // R7
  stop_drops_disp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_trig |=> (!pnl_disp_en && seq_status == 2'b11 && !on_q));

endmodule

bind disp_pwr_seq disp_seq_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ctrl_run     (ctrl_run),
  .pnl_logic_en (pnl_logic_en),
  .pnl_drive_en (pnl_drive_en),
  .pnl_disp_en  (pnl_disp_en),
  .seq_status   (seq_status),
  .done_irq     (done_irq),
  .on_q         (on_q),
  .start_q      (start_q),
  .err_q        (err_q),
  .busy_wr      (busy_wr),
  .start_trig   (start_trig),
  .stop_trig    (stop_trig),
  .done_pulse   (done_pulse)
);

// File: tb/sim_disp_pwr_seq.sv
module sim_disp_pwr_seq;

  localparam int DL = 3;
  localparam int DD = 4;
  localparam int DS = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        ctrl_run, pnl_logic_en, pnl_drive_en, pnl_disp_en, done_irq;
  logic [1:0]  seq_status;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  typedef struct {
    int         at;
    logic [5:0] vec;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  disp_pwr_seq #(.ADDR_W(2), .DLY_LOGIC(DL), .DLY_DRIVE(DD), .DLY_DISP(DS)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ctrl_run(ctrl_run),
    .pnl_logic_en(pnl_logic_en), .pnl_drive_en(pnl_drive_en),
    .pnl_disp_en(pnl_disp_en), .seq_status(seq_status), .done_irq(done_irq)
  );

  function automatic logic [5:0] outs();
    return {seq_status, ctrl_run, pnl_logic_en, pnl_drive_en, pnl_disp_en};
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: pops expected output patterns at their cycle
  always @(negedge clk) begin
    while (exp_q.size() > 0 && exp_q[0].at == cyc) begin
      exp_t  e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, {10'd0, outs()}, {10'd0, e.vec});
    end
  end

  // One register write; returns the cycle index seen after the sampling edge
  task automatic wr(input logic [1:0] a, input logic [15:0] d, output int base);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    base = cyc + 1;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
    bus_addr = '0;
  endtask

  task automatic push(input int at, input logic [5:0] v, input string t);
    exp_t e;
    e.at = at; e.vec = v;
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  // Driver: issue a start and predict the power-up timeline
  task automatic do_start(output int base);
    wr(2'd0, 16'h0011, base);
    push(base,             6'b00_1000, "R4 R5 run first");
    push(base + DL,        6'b01_1100, "R4 R5 logic up");
    push(base + DL + DD,   6'b01_1110, "R4 drive up");
    push(base + DL+DD+DS,  6'b11_1111, "R4 R5 display up");
  endtask

  task automatic do_stop(output int base);
    wr(2'd0, 16'h0000, base);
    push(base,             6'b11_1110, "R7 display down");
    push(base + DS,        6'b01_1100, "R6 R7 drive down");
    push(base + DS + DD,   6'b01_1000, "R7 logic down");
    push(base + DS+DD+DL,  6'b00_0000, "R7 controller stop");
  endtask

  task automatic wait_drain();
    while (exp_q.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [15:0] r;
    int b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 reset outputs", {10'd0, outs()}, 16'd0);
    rd(2'd0, r); check("R1 reset ctrl", r, 16'h0000);

    // R3 on without start does nothing
    wr(2'd0, 16'h0001, b);
    repeat (DL + DD + DS + 2) @(negedge clk);
    check("R3 on-only outputs", {10'd0, outs()}, 16'd0);
    rd(2'd0, r); check("R3 on-only ctrl", r, 16'h0000);

    // Power-up
    do_start(b);
    @(negedge clk);
    // cycle base+1: start bit already cleared
    rd(2'd0, r); check("R2 start self-cleared", r, 16'h0001);
    // write during busy: ignored, error flag
    wr(2'd0, 16'h0000, b);
    wait_drain();
    rd(2'd0, r); check("R8 busy write kept on", r, 16'h0001);
    rd(2'd1, r); check("R8 R9 event reg", r, 16'h0033);
    check("R9 irq", {15'd0, done_irq}, 16'd1);
    wr(2'd1, 16'h0030, b);
    rd(2'd1, r); check("R8 R9 flags cleared", r, 16'h0003);
    check("R9 irq cleared", {15'd0, done_irq}, 16'd0);

    // R1 reserved bits in on state, no stop
    wr(2'd0, 16'hFFEF, b);
    repeat (2) @(negedge clk);
    rd(2'd0, r); check("R1 reserved ignored", r, 16'h0001);
    check("R1 still on", {10'd0, outs()}, 16'h003F);

    // Power-down with a write in the middle
    do_stop(b);
    repeat (DS + 1) @(negedge clk);
    wr(2'd0, 16'h0011, b);
    wait_drain();
    rd(2'd0, r); check("R8 busy start ignored", r, 16'h0000);
    rd(2'd1, r); check("R8 R9 event after off", r, 16'h0030);
    wr(2'd1, 16'h0030, b);

    // R3 second start from clean off
    do_start(b);
    wait_drain();
    rd(2'd1, r); check("R3 R9 restart done", r, 16'h0013);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule